// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block decides which clock source feeds a small processor core after a reset or a wake from sleep. When fast start-up is enabled and the primary oscillator is a crystal, the core is handed the internal oscillator at once, so code can run while a start-up counter qualifies the crystal. Once the crystal has produced enough edges (and, in PLL modes, once the PLL lock interval has also passed), the block moves the core to the primary clock by itself and raises a status bit.

Software stays in charge during the whole wait. It may select the internal oscillator, select the primary one again, or request sleep before the start-up count completes. A short wake followed by a return to sleep never touches the primary clock. In external-clock modes the start-up count is skipped and the internal path is not used unless software asks for it. The block runs on an always-on control clock. The primary oscillator is seen only as a raw edge input, and the clock-mux cell is driven by a one-hot select output.

Top module: `fastboot_clksel`

## Requirements
- R1: After `rst_n` is released, `src_sel` is 2'b00, `pri_active` is 0 and `core_asleep` is 0. The block behaves as after a power-on event, so it waits for the power-up timer.
- R2: After a power-on event (`por_evt`, or release of `rst_n`), `src_sel` stays 2'b00 until `pwrt_done` is 1. Only then does the block select a source.
- R3: With `cfg_fast_en`=1, a crystal mode (`cfg_mode[1]`=0) and `clk_sel`=2'b00, a restart selects the internal oscillator (`src_sel`=2'b01) with `pri_active`=0.
- R4: With `clk_sel`=2'b00 and either `cfg_fast_en`=0 or an external mode (`cfg_mode[1]`=1), no source is selected (2'b00) until the primary is ready. The block then goes straight to `src_sel`=2'b10.
- R5: In crystal modes the primary becomes ready only after OST_EDGES (default 1024) rising edges of `pri_osc_in`, counted after a two-flop synchronizer. External modes skip this count.
- R6: In PLL modes (`cfg_mode[0]`=1), PLL_LOCK_CYC further control-clock cycles must pass after the count before the primary is ready.
- R7: While on the internal source with `clk_sel`=2'b00, the switch to the primary happens without software action once the primary is ready. `pri_active` is 1 exactly while `src_sel`=2'b10.
- R8: `src_sel` is never 2'b11. Between 2'b01 and 2'b10, in either direction, it reads 2'b00 for exactly GAP_CYCLES (default 2) cycles.
- R9: Any `clk_sel` other than 2'b00 selects the internal oscillator (`src_sel` bit 0; bit 1 is the primary), whatever `cfg_fast_en` is. Returning `clk_sel` to 2'b00 moves to the primary only once it is ready.
- R10: `sleep_req` while a source is running gives `core_asleep`=1 and `src_sel`=2'b00. The start-up and PLL counters are held at zero during sleep. A `wake_evt` restarts selection and the full edge count.
- R11: `wake_evt` has no effect while the core is not asleep. `rst_evt` restarts selection and clears both counters from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| cfg_mode | input | 2 | Oscillator mode: bit1 = external clock, bit0 = PLL used |
| cfg_fast_en | input | 1 | Configuration enable for fast start-up on the internal clock |
| por_evt | input | 1 | Power-on reset event pulse (waits for power-up timer) |
| rst_evt | input | 1 | Other reset event pulse |
| wake_evt | input | 1 | Wake-from-sleep event pulse |
| sleep_req | input | 1 | Sleep request from the core |
| clk_sel | input | 2 | Software clock select; 2'b00 = primary, other = internal |
| pri_osc_in | input | 1 | Raw primary oscillator output, asynchronous |
| pwrt_done | input | 1 | Power-up timer expired |
| src_sel | output | 2 | One-hot clock mux select: bit0 internal, bit1 primary, 0 = none |
| pri_active | output | 1 | Status: primary oscillator clocks the core |
| core_asleep | output | 1 | Core is in sleep |

## Verification
The hardest case to reach from the ports is a wake that is followed by a new sleep request before the start-up count completes, with primary edges still arriving while the core sleeps. The only visible proof that the counter was held and then restarted is the timing of a later switch to the primary. The stimulus gives a partial edge count and then sleeps. It drives more than a full count of edges during sleep and wakes the core. It then shows that a count well short of the threshold still leaves the core on the internal clock, and that only the remainder of a full count brings the primary in.

// File: rtl/fastboot_pkg.sv
`timescale 1ns/1ps
package fastboot_pkg;

  typedef enum logic [2:0] {
    ST_HOLD    = 3'd0,
    ST_WAITPRI = 3'd1,
    ST_INT     = 3'd2,
    ST_GAP     = 3'd3,
    ST_PRI     = 3'd4,
    ST_SLEEP   = 3'd5
  } fb_state_t;

  localparam logic [1:0] SRC_NONE = 2'b00;
  localparam logic [1:0] SRC_INT  = 2'b01;
  localparam logic [1:0] SRC_PRI  = 2'b10;

  // external clock modes need no start-up edge count
  function automatic logic mode_external(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic logic mode_pll(input logic [1:0] mode);
    return mode[0];
  endfunction

  // start on internal clock: software choice, or fast start on a crystal
  function automatic logic start_internal(input logic fast_en,
                                          input logic [1:0] mode,
                                          input logic [1:0] sel);
    return (sel != 2'b00) || (fast_en && !mode_external(mode));
  endfunction

  function automatic logic [1:0] state_src(input fb_state_t st);
    case (st)
      ST_INT:  return SRC_INT;
      ST_PRI:  return SRC_PRI;
      default: return SRC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fb_edge_sync.sv
`timescale 1ns/1ps
module fb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  // chain[STAGES-1] is the last synchronizer flop, chain[STAGES] its delay
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fb_sat_counter.sv
`timescale 1ns/1ps
module fb_sat_counter #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic done,
  output logic empty
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (clear)                     cnt <= '0;
    else if (inc && cnt != W'(LIMIT))   cnt <= cnt + 1'b1;
  end

  assign done  = (cnt == W'(LIMIT));
  assign empty = (cnt == '0);
endmodule

// File: rtl/fb_src_fsm.sv
`timescale 1ns/1ps
module fb_src_fsm
  import fastboot_pkg::*;
#(
  parameter int GAP_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_evt,
  input  logic       rst_evt,
  input  logic       wake_evt,
  input  logic       sleep_req,
  input  logic       pwrt_done,
  input  logic       fast_en,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] clk_sel,
  input  logic       pri_ok,
  output logic       restart,
  output logic [1:0] src_sel,
  output logic       pri_active,
  output logic       asleep
);
  localparam int GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  fb_state_t   st_q, st_d;
  logic        pend_q, pend_d;
  logic        to_pri_q, to_pri_d;
  logic [GW-1:0] gap_q, gap_d;
  logic        gap_end;
  logic        wake_hit;

  assign wake_hit = wake_evt && (st_q == ST_SLEEP);
  assign restart  = por_evt || rst_evt || wake_hit;
  assign gap_end  = (gap_q == GW'(GAP_CYCLES - 1));

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    to_pri_d = to_pri_q;
    gap_d    = '0;
    if (por_evt) begin
      st_d   = ST_HOLD;
      pend_d = 1'b1;
    end else if (rst_evt || wake_hit) begin
      st_d = ST_HOLD;
    end else begin
      case (st_q)
        ST_HOLD: begin
          if (!pend_q || pwrt_done) begin
            pend_d = 1'b0;
            st_d   = start_internal(fast_en, cfg_mode, clk_sel) ? ST_INT : ST_WAITPRI;
          end
        end
        ST_WAITPRI: if (pri_ok) st_d = ST_PRI;
        ST_INT: begin
          if (sleep_req) st_d = ST_SLEEP;
          else if (clk_sel == 2'b00 && pri_ok) begin
            st_d     = ST_GAP;
            to_pri_d = 1'b1;
          end
        end
        ST_PRI: begin
          if (sleep_req) st_d = ST_SLEEP;
          else if (clk_sel != 2'b00) begin
            st_d     = ST_GAP;
            to_pri_d = 1'b0;
          end
        end
        ST_GAP: begin
          if (gap_end) st_d = to_pri_q ? ST_PRI : ST_INT;
          else         gap_d = gap_q + 1'b1;
        end
        ST_SLEEP: st_d = ST_SLEEP;
        default:  st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_HOLD;
      pend_q     <= 1'b1;
      to_pri_q   <= 1'b0;
      gap_q      <= '0;
      src_sel    <= SRC_NONE;
      pri_active <= 1'b0;
      asleep     <= 1'b0;
    end else begin
      st_q       <= st_d;
      pend_q     <= pend_d;
      to_pri_q   <= to_pri_d;
      gap_q      <= gap_d;
      src_sel    <= state_src(st_d);
      pri_active <= (st_d == ST_PRI);
      asleep     <= (st_d == ST_SLEEP);
    end
  end
endmodule

// File: rtl/fastboot_clksel.sv
`timescale 1ns/1ps
module fastboot_clksel
  import fastboot_pkg::*;
#(
  parameter int OST_EDGES    = 1024,
  parameter int PLL_LOCK_CYC = 1500,
  parameter int GAP_CYCLES   = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_fast_en,
  input  logic       por_evt,
  input  logic       rst_evt,
  input  logic       wake_evt,
  input  logic       sleep_req,
  input  logic [1:0] clk_sel,
  input  logic       pri_osc_in,
  input  logic       pwrt_done,
  output logic [1:0] src_sel,
  output logic       pri_active,
  output logic       core_asleep
);
  // named internal events
  logic pri_rise;
  logic restart;
  logic cnt_clear;
  logic ost_done, ost_empty;
  logic pll_done, pll_empty;
  logic ost_ok, pll_ok, pri_ok;

  fb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pri_osc_in), .rise(pri_rise)
  );

  assign cnt_clear = restart || core_asleep;

  fb_sat_counter #(.LIMIT(OST_EDGES)) u_ost (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .inc(pri_rise),
    .done(ost_done), .empty(ost_empty)
  );

  assign ost_ok = mode_external(cfg_mode) || ost_done;

  fb_sat_counter #(.LIMIT(PLL_LOCK_CYC)) u_pll (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .inc(ost_ok),
    .done(pll_done), .empty(pll_empty)
  );

  assign pll_ok = !mode_pll(cfg_mode) || pll_done;
  assign pri_ok = ost_ok && pll_ok;

  fb_src_fsm #(.GAP_CYCLES(GAP_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .rst_evt(rst_evt),
    .wake_evt(wake_evt), .sleep_req(sleep_req), .pwrt_done(pwrt_done),
    .fast_en(cfg_fast_en), .cfg_mode(cfg_mode), .clk_sel(clk_sel),
    .pri_ok(pri_ok), .restart(restart), .src_sel(src_sel),
    .pri_active(pri_active), .asleep(core_asleep)
  );
endmodule

// File: rtl/fastboot_clksel_chk.sv
`timescale 1ns/1ps
module fastboot_clksel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] src_sel,
  input logic       pri_active,
  input logic       core_asleep,
  input logic       sleep_req,
  input logic       restart,
  input logic       pri_ok,
  input logic       ost_empty,
  input logic       pll_empty
);
  assert_src_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_sel));

  assert_no_int_to_pri_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel) == 2'b01) |-> (src_sel != 2'b10));

  assert_no_pri_to_int_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel) == 2'b10) |-> (src_sel != 2'b01));

  assert_switch_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_sel[1]) |-> $past(pri_ok));

  assert_restart_clears_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !pri_active);

  assert_sleep_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && src_sel != 2'b00 && !restart) |=> core_asleep);

  assert_sleep_holds_counters_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_asleep && $past(core_asleep)) |-> (ost_empty && pll_empty));
endmodule

bind fastboot_clksel fastboot_clksel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pri_active(pri_active),
  .core_asleep(core_asleep), .sleep_req(sleep_req), .restart(restart),
  .pri_ok(pri_ok), .ost_empty(ost_empty), .pll_empty(pll_empty)
);

// File: tb/test_fastboot_clksel.sv
`timescale 1ns/1ps
module test_fastboot_clksel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_fast_en = 1'b1;
  logic       por_evt = 1'b0, rst_evt = 1'b0, wake_evt = 1'b0, sleep_req = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic       pri_osc_in = 1'b0;
  logic       pwrt_done = 1'b0;
  logic [1:0] src_sel;
  logic       pri_active, core_asleep;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fastboot_clksel i_fastboot_clksel (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fast_en(cfg_fast_en),
    .por_evt(por_evt), .rst_evt(rst_evt), .wake_evt(wake_evt),
    .sleep_req(sleep_req), .clk_sel(clk_sel), .pri_osc_in(pri_osc_in),
    .pwrt_done(pwrt_done), .src_sel(src_sel), .pri_active(pri_active),
    .core_asleep(core_asleep)
  );

  // mode, fast, sel, source after restart, source once ready
  typedef struct packed {
    logic [1:0] mode;
    logic       fast;
    logic [1:0] sel;
    logic [1:0] early;
    logic [1:0] late;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b00, 1'b1, 2'b00, 2'b01, 2'b10},
    '{2'b00, 1'b0, 2'b00, 2'b00, 2'b10},
    '{2'b01, 1'b1, 2'b00, 2'b01, 2'b10},
    '{2'b10, 1'b1, 2'b00, 2'b10, 2'b10},
    '{2'b10, 1'b0, 2'b00, 2'b10, 2'b10},
    '{2'b11, 1'b1, 2'b00, 2'b00, 2'b10},
    '{2'b00, 1'b1, 2'b01, 2'b01, 2'b01},
    '{2'b10, 1'b0, 2'b10, 2'b01, 2'b01}
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pri_edges(input int n);
    repeat (n) begin
      pri_osc_in = 1'b1; cycles(2);
      pri_osc_in = 1'b0; cycles(2);
    end
  endtask

  task automatic pulse_rst();
    rst_evt = 1'b1; cycles(1); rst_evt = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state, power-up timer not yet done
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    check("R1 src_sel", src_sel, 2'b00);
    check("R1 pri_active", {1'b0, pri_active}, 2'b00);
    check("R1 core_asleep", {1'b0, core_asleep}, 2'b00);
    cycles(20);
    check("R2 held until pwrt_done", src_sel, 2'b00);
    pwrt_done = 1'b1;
    cycles(3);
    check("R2/R3 internal after pwrt_done", src_sel, 2'b01);
    // power-on event again with timer pending
    pwrt_done = 1'b0;
    por_evt = 1'b1; cycles(1); por_evt = 1'b0;
    cycles(10);
    check("R2 por waits for timer", src_sel, 2'b00);
    pwrt_done = 1'b1;
    cycles(3);
    check("R2 por then timer done", src_sel, 2'b01);

    // table walk: each configuration from a fresh reset event
    foreach (VECS[i]) begin
      cfg_mode    = VECS[i].mode;
      cfg_fast_en = VECS[i].fast;
      clk_sel     = VECS[i].sel;
      pulse_rst();
      cycles(8);
      check($sformatf("R3/R4/R9 vec%0d early src", i), src_sel, VECS[i].early);
      check($sformatf("R11 vec%0d status after restart", i), {1'b0, pri_active},
            {1'b0, VECS[i].early == 2'b10});
      pri_edges(1000);
      check($sformatf("R5 vec%0d below edge count", i), src_sel,
            VECS[i].mode[1] ? VECS[i].late : VECS[i].early);
      pri_edges(100);
      if (VECS[i].mode[0])
        check($sformatf("R6 vec%0d pll lock pending", i), src_sel,
              VECS[i].mode[1] ? VECS[i].late : VECS[i].early);
      cycles(1600);
      check($sformatf("R6/R7 vec%0d late src", i), src_sel, VECS[i].late);
      check($sformatf("R7 vec%0d status", i), {1'b0, pri_active},
            {1'b0, VECS[i].late == 2'b10});
    end

    // R8/R9: software switches with exact gap
    cfg_mode = 2'b00; cfg_fast_en = 1'b1; clk_sel = 2'b01;
    pulse_rst();
    pri_edges(1100);
    check("R9 internal kept while selected", src_sel, 2'b01);
    clk_sel = 2'b00;
    cycles(1);
    check("R8 gap cycle 1 to primary", src_sel, 2'b00);
    cycles(1);
    check("R8 gap cycle 2 to primary", src_sel, 2'b00);
    cycles(1);
    check("R8/R7 primary after gap", src_sel, 2'b10);
    check("R7 status on primary", {1'b0, pri_active}, 2'b01);
    clk_sel = 2'b11;
    cycles(1);
    check("R8 gap cycle 1 to internal", src_sel, 2'b00);
    check("R7 status off in gap", {1'b0, pri_active}, 2'b00);
    cycles(2);
    check("R8/R9 internal after gap", src_sel, 2'b01);

    // R11: wake while running is ignored, count survives
    wake_evt = 1'b1; cycles(1); wake_evt = 1'b0;
    cycles(3);
    check("R11 wake ignored src", src_sel, 2'b01);
    clk_sel = 2'b00;
    cycles(4);
    check("R11 count kept after ignored wake", src_sel, 2'b10);

    // R10: brief wake, sleep again, count restarts
    pulse_rst();
    cycles(4);
    check("R3 internal before sleep test", src_sel, 2'b01);
    pri_edges(500);
    sleep_req = 1'b1; cycles(1); sleep_req = 1'b0;
    cycles(1);
    check("R10 asleep", {1'b0, core_asleep}, 2'b01);
    check("R10 no source in sleep", src_sel, 2'b00);
    pri_edges(1200);
    check("R10 still asleep after edges", {1'b0, core_asleep}, 2'b01);
    check("R10 no source after edges", src_sel, 2'b00);
    wake_evt = 1'b1; cycles(1); wake_evt = 1'b0;
    cycles(3);
    check("R10 internal after wake", src_sel, 2'b01);
    check("R10 awake", {1'b0, core_asleep}, 2'b00);
    pri_edges(600);
    check("R10 count restarted after wake", src_sel, 2'b01);
    pri_edges(500);
    cycles(4);
    check("R10/R7 primary after full count", src_sel, 2'b10);

    // R11: reset event from primary run
    pulse_rst();
    cycles(1);
    check("R11 restart drops status", {1'b0, pri_active}, 2'b00);
    cycles(3);
    check("R11 restart reselects internal", src_sel, 2'b01);

    finished = 1;
    summary();
    $finish;
  end
endmodule